// File: doc/BRIEF.md
# ADC Power-Mode Host Controller

This block is the host side of a serial link to a 12-bit sampling converter. The converter has three power states, and it changes state only according to where chip-select rises within a frame. The controller drives chip-select and a serial clock that idles high. The serial clock comes from the system clock through a parameterised divider. Serial data is sampled on every falling serial-clock edge. A full frame carries 16 bits: four zero bits come first, and the 12-bit result fills the low end.

Software issues one of five commands: convert, go to partial power-down, go to full power-down, wake, or initialise-to-mode. The controller expands each command into a sequence of frames of three kinds. A full conversion frame runs 16 edges and keeps its data. A dummy frame also runs 16 edges, but its data is thrown away. An aborted frame ends after `ABORT_EDGE` falling edges, a count that lies inside the window of edges that powers the converter down. A quiet gap follows every frame. A longer power-up wait follows any dummy frame that may have woken the converter from full power-down. Busy stays high until the last gap has ended. The controller keeps its own record of the converter's power state and shows it on an output.

Top module: `adcPwrHost`

## Requirements
- R1: While reset is held and just after it, `csN`=1, `sclk`=1, `busy`=0, `resValid`=0 and `pwrState`=2. The state encoding is 0 normal, 1 partial power-down, 2 full power-down. Full power-down is assumed at reset.
- R2: A command is accepted when `cmdValid` is high and `busy` is low. The op codes are 0 convert, 1 partial, 2 full, 3 wake and 4 init. `cmdValid` has no effect while `busy` is high.
- R3: A conversion frame gives exactly 16 falling `sclk` edges while `csN` is low, and `sclk` is high whenever `csN` is high. `resValid` pulses for one cycle in the cycle where `csN` has just risen. `resData` then holds the last 12 bits sampled, MSB first.
- R4: Partial power-down requested in normal state issues one frame. That frame raises `csN` after exactly `ABORT_EDGE` (default 5) falling edges, and `pwrState` becomes 1.
- R5: Full power-down issues two aborted frames when starting from normal and one when starting from partial power-down. `pwrState` becomes 2.
- R6: Wake from a power-down state issues one 16-edge dummy frame without pulsing `resValid`, and `pwrState` becomes 0.
- R7: After a dummy frame that starts from full power-down, at least `QUIET_CYC`+`PWRUP_CYC` cycles pass from the rise of `csN` to its next fall.
- R8: Between any two frames, `csN` stays high for at least `QUIET_CYC` cycles.
- R9: Convert outside normal state first issues a dummy frame and then the conversion. The power-up wait is inserted only when starting from full power-down.
- R10: Init with `cmdMode`=m (0, 1 or 2) issues a dummy frame, then the power-up wait, then m aborted frames, and `pwrState` becomes m. Mode 3 is treated as 0.
- R11: A command that is already satisfied, and op codes 5 to 7, issue no frame, hold `busy` high for exactly one cycle and leave `pwrState` unchanged.
- R12: Partial power-down requested in full power-down state issues a dummy frame, then the power-up wait, then one aborted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request strobe |
| cmdOp | input | 3 | Command code |
| cmdMode | input | 2 | Target state for init |
| busy | output | 1 | Sequence in progress |
| resValid | output | 1 | One-cycle result strobe |
| resData | output | RES_BITS | Conversion result |
| pwrState | output | 2 | Power state the controller believes the converter is in |
| csN | output | 1 | Converter chip-select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdata | input | 1 | Serial data from converter |

## Verification
The hardest conditions to reach from the ports are the ones that depend on the controller's stored belief about power state: the power-up wait after a wake from full power-down, and the command that needs no frames at all. The bench reaches every starting state by first issuing an init command with each mode. It then sends every op code from that state. A bench model of the converter follows the edge counts seen on the wire, so the bench knows the true power state independently of the design. A command injected during a sequence shows whether busy-time requests are really ignored.

// File: rtl/adcHostPkg.sv
`timescale 1ns/1ps
package adcHostPkg;
  typedef enum logic [1:0] {PWR_NORMAL = 2'd0, PWR_PARTIAL = 2'd1, PWR_FULL = 2'd2} pwrState_t;
  typedef enum logic [1:0] {KIND_DUMMY, KIND_ABORT, KIND_CONV} frameKind_t;

  localparam logic [2:0] OP_CONVERT = 3'd0;
  localparam logic [2:0] OP_PARTIAL = 3'd1;
  localparam logic [2:0] OP_FULL    = 3'd2;
  localparam logic [2:0] OP_WAKE    = 3'd3;
  localparam logic [2:0] OP_INIT    = 3'd4;

  typedef struct packed {
    logic startFrame;
    logic abortFrame;
    logic captureFrame;
    logic startQuiet;
    logic startPwrWait;
  } dpStrobe_t;
endpackage

// File: rtl/adcPwrHostCtrl.sv
`timescale 1ns/1ps
module adcPwrHostCtrl
  import adcHostPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdMode,
  input  logic       frameDone,
  input  logic       timerDone,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic [1:0] pwrState
);
  typedef enum logic [2:0] {S_IDLE, S_NEXT, S_FRAME, S_GAP, S_WAIT} ctrlState_t;

  ctrlState_t state;
  frameKind_t kind, pickKind;
  pwrState_t  pwrQ;
  logic       needDummy, needWait, needConv;
  logic [1:0] abortsLeft;
  logic       pDummy, pWait, pConv;
  logic [1:0] pAborts;
  logic       pickFrame, pickWait, goPick;

  // Expand a command into a plan, given the state believed now
  always_comb begin
    pDummy = 1'b0; pWait = 1'b0; pConv = 1'b0; pAborts = 2'd0;
    case (cmdOp)
      OP_CONVERT: begin
        pDummy = (pwrQ != PWR_NORMAL);
        pWait  = (pwrQ == PWR_FULL);
        pConv  = 1'b1;
      end
      OP_PARTIAL: begin
        pDummy  = (pwrQ == PWR_FULL);
        pWait   = (pwrQ == PWR_FULL);
        pAborts = (pwrQ == PWR_PARTIAL) ? 2'd0 : 2'd1;
      end
      OP_FULL: pAborts = (pwrQ == PWR_NORMAL) ? 2'd2 : (pwrQ == PWR_PARTIAL) ? 2'd1 : 2'd0;
      OP_WAKE: begin
        pDummy = (pwrQ != PWR_NORMAL);
        pWait  = (pwrQ == PWR_FULL);
      end
      OP_INIT: begin
        pDummy  = 1'b1;
        pWait   = 1'b1;
        pAborts = (cmdMode == 2'd3) ? 2'd0 : cmdMode;
      end
      default: ;
    endcase
  end

  // Next step in fixed order: dummy, wait, aborts, conversion
  always_comb begin
    pickFrame = 1'b0; pickWait = 1'b0; pickKind = KIND_CONV;
    if (needDummy) begin
      pickFrame = 1'b1; pickKind = KIND_DUMMY;
    end else if (needWait) begin
      pickWait = 1'b1;
    end else if (abortsLeft != 2'd0) begin
      pickFrame = 1'b1; pickKind = KIND_ABORT;
    end else if (needConv) begin
      pickFrame = 1'b1; pickKind = KIND_CONV;
    end
  end

  assign goPick = (state == S_NEXT) || (((state == S_GAP) || (state == S_WAIT)) && timerDone);

  always_comb begin
    strobe.startFrame   = goPick && pickFrame;
    strobe.abortFrame   = (pickKind == KIND_ABORT);
    strobe.captureFrame = (pickKind == KIND_CONV);
    strobe.startQuiet   = (state == S_FRAME) && frameDone;
    strobe.startPwrWait = goPick && pickWait;
  end

  assign busy     = (state != S_IDLE);
  assign pwrState = pwrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      kind       <= KIND_DUMMY;
      pwrQ       <= PWR_FULL;
      needDummy  <= 1'b0;
      needWait   <= 1'b0;
      needConv   <= 1'b0;
      abortsLeft <= 2'd0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          needDummy  <= pDummy;
          needWait   <= pWait;
          needConv   <= pConv;
          abortsLeft <= pAborts;
          state      <= S_NEXT;
        end
        S_FRAME: if (frameDone) begin
          state <= S_GAP;
          if (kind == KIND_ABORT)
            pwrQ <= (pwrQ == PWR_NORMAL) ? PWR_PARTIAL : PWR_FULL;
          else
            pwrQ <= PWR_NORMAL;
        end
        default: if (goPick) begin
          if (pickFrame) begin
            state <= S_FRAME;
            kind  <= pickKind;
            case (pickKind)
              KIND_DUMMY: needDummy <= 1'b0;
              KIND_ABORT: abortsLeft <= abortsLeft - 2'd1;
              default:    needConv <= 1'b0;
            endcase
          end else if (pickWait) begin
            needWait <= 1'b0;
            state    <= S_WAIT;
          end else begin
            state <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adcPwrHostDp.sv
`timescale 1ns/1ps
module adcPwrHostDp
  import adcHostPkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int FRAME_EDGES = 16,
  parameter int RES_BITS    = 12,
  parameter int ABORT_EDGE  = 5,
  parameter int QUIET_CYC   = 4,
  parameter int PWRUP_CYC   = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                sdata,
  output logic                csN,
  output logic                sclk,
  output logic                frameDone,
  output logic                timerDone,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData
);
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int EDGE_W = $clog2(FRAME_EDGES + 1);
  localparam int TMR_MAX = (QUIET_CYC > PWRUP_CYC) ? QUIET_CYC : PWRUP_CYC;
  localparam int TMR_W  = $clog2(TMR_MAX + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(CLK_DIV - 1);
  localparam logic [EDGE_W-1:0] FULL_LIMIT = EDGE_W'(FRAME_EDGES);
  localparam logic [EDGE_W-1:0] ABRT_LIMIT = EDGE_W'(ABORT_EDGE);

  logic                   frmRun, capture;
  logic [DIV_W-1:0]       divCnt;
  logic [EDGE_W-1:0]      edgeCnt, edgeLimit;
  logic [FRAME_EDGES-1:0] shiftQ;
  logic                   tmrRun;
  logic [TMR_W-1:0]       tmrCnt;

  // Frame engine: half-period divider, falling-edge counter, capture shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmRun <= 1'b0; capture <= 1'b0; csN <= 1'b1; sclk <= 1'b1;
      divCnt <= '0; edgeCnt <= '0; edgeLimit <= '0; shiftQ <= '0;
      frameDone <= 1'b0; resValid <= 1'b0; resData <= '0;
    end else begin
      frameDone <= 1'b0;
      resValid  <= 1'b0;
      if (strobe.startFrame) begin
        frmRun    <= 1'b1;
        csN       <= 1'b0;
        sclk      <= 1'b1;
        divCnt    <= '0;
        edgeCnt   <= '0;
        edgeLimit <= strobe.abortFrame ? ABRT_LIMIT : FULL_LIMIT;
        capture   <= strobe.captureFrame;
      end else if (frmRun) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (sclk) begin
            sclk    <= 1'b0;
            edgeCnt <= edgeCnt + 1'b1;
            shiftQ  <= {shiftQ[FRAME_EDGES-2:0], sdata};
          end else begin
            sclk <= 1'b1;
            if (edgeCnt == edgeLimit) begin
              frmRun    <= 1'b0;
              csN       <= 1'b1;
              frameDone <= 1'b1;
              if (capture) begin
                resValid <= 1'b1;
                resData  <= shiftQ[RES_BITS-1:0];
              end
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  // Shared down-counter for quiet gap and power-up wait
  assign timerDone = tmrRun && (tmrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrRun <= 1'b0;
      tmrCnt <= '0;
    end else if (strobe.startQuiet) begin
      tmrRun <= 1'b1;
      tmrCnt <= TMR_W'(QUIET_CYC - 1);
    end else if (strobe.startPwrWait) begin
      tmrRun <= 1'b1;
      tmrCnt <= TMR_W'(PWRUP_CYC - 1);
    end else if (tmrRun) begin
      if (tmrCnt == '0) tmrRun <= 1'b0;
      else              tmrCnt <= tmrCnt - 1'b1;
    end
  end
endmodule

// File: rtl/adcPwrHost.sv
`timescale 1ns/1ps
module adcPwrHost
  import adcHostPkg::*;
#(
  parameter int CLK_DIV     = 2,
  parameter int FRAME_EDGES = 16,
  parameter int RES_BITS    = 12,
  parameter int ABORT_EDGE  = 5,
  parameter int QUIET_CYC   = 4,
  parameter int PWRUP_CYC   = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [2:0]          cmdOp,
  input  logic [1:0]          cmdMode,
  output logic                busy,
  output logic                resValid,
  output logic [RES_BITS-1:0] resData,
  output logic [1:0]          pwrState,
  output logic                csN,
  output logic                sclk,
  input  logic                sdata
);
  dpStrobe_t strobe;
  logic      frameDone, timerDone;

  adcPwrHostCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMode(cmdMode),
    .frameDone(frameDone), .timerDone(timerDone), .strobe(strobe),
    .busy(busy), .pwrState(pwrState)
  );

  adcPwrHostDp #(
    .CLK_DIV(CLK_DIV), .FRAME_EDGES(FRAME_EDGES), .RES_BITS(RES_BITS),
    .ABORT_EDGE(ABORT_EDGE), .QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdata(sdata), .csN(csN), .sclk(sclk),
    .frameDone(frameDone), .timerDone(timerDone), .resValid(resValid), .resData(resData)
  );
endmodule

// File: rtl/adcPwrHostChk.sv
`timescale 1ns/1ps
module adcPwrHostChk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       resValid,
  input logic       csN,
  input logic       sclk,
  input logic [1:0] pwrState
);
  a_r11_idle_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);
  a_r3_sclk_idles_high: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);
  a_r3_result_at_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (csN && !$past(csN)));
  a_r6_result_only_normal: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (pwrState == 2'd0));
  a_r2_state_held_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(pwrState));
  a_r8_frame_starts_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> busy);
  a_r5_legal_state: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3);
endmodule

bind adcPwrHost adcPwrHostChk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .resValid(resValid),
  .csN(csN), .sclk(sclk), .pwrState(pwrState)
);

// File: tb/adcPwrHost_tb.sv
`timescale 1ns/1ps
module adcPwrHost_tb;
  localparam int CLK_DIV = 2;
  localparam int QUIET   = 4;
  localparam int PWRUP   = 20;
  localparam int ABORT   = 5;

  logic        clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0, sdata = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [1:0]  cmdMode = 2'd0;
  logic        busy, resValid, csN, sclk;
  logic [11:0] resData;
  logic [1:0]  pwrState;

  adcPwrHost #(.CLK_DIV(CLK_DIV), .ABORT_EDGE(ABORT), .QUIET_CYC(QUIET), .PWRUP_CYC(PWRUP)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdMode(cmdMode),
    .busy(busy), .resValid(resValid), .resData(resData), .pwrState(pwrState),
    .csN(csN), .sclk(sclk), .sdata(sdata)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Converter model: shifts a frame out and follows the power state from edge counts
  logic [15:0] frameWord = 16'h0;
  int  bitIdx = 15, edgeCnt = 0, frameCnt = 0, modelSt = 2, stBefore = 2;
  int  resCnt = 0, gapViol = 0, pwrViol = 0, edgeViol = 0, lastGap = 0;
  bit  firstFrame = 1'b1, wokeFromFull = 1'b0;
  longint tEnd = 0;
  logic [11:0] lastRes = 12'h0;

  always @(negedge csN) if (rstN) begin
    if (!firstFrame) begin
      lastGap = int'(($time - tEnd) / 10);
      if (lastGap < QUIET) gapViol++;
      if (wokeFromFull && lastGap < QUIET + PWRUP) pwrViol++;
    end
    firstFrame = 1'b0;
    edgeCnt  = 0;
    stBefore = modelSt;
    bitIdx   = 15;
    #1 sdata = frameWord[15];
  end

  always @(negedge sclk) if (rstN && !csN) begin
    edgeCnt++;
    bitIdx--;
    #1 if (bitIdx >= 0) sdata = frameWord[bitIdx];
  end

  always @(posedge csN) if (rstN) begin
    frameCnt++;
    wokeFromFull = (edgeCnt >= 10) && (stBefore == 2);
    if (edgeCnt >= 10) begin
      if (edgeCnt != 16) edgeViol++;
      modelSt = 0;
    end else if (edgeCnt >= 2) begin
      if (edgeCnt != ABORT) edgeViol++;
      modelSt = (modelSt == 0) ? 1 : 2;
    end else begin
      edgeViol++;
    end
    sdata = 1'b0;
    tEnd  = $time;
  end

  always @(negedge clk) if (rstN && resValid) begin
    resCnt++;
    lastRes = resData;
  end

  function automatic int expFrames(int op, int mode, int s);
    case (op)
      0: return (s != 0) ? 2 : 1;
      1: return (s == 0) ? 1 : ((s == 1) ? 0 : 2);
      2: return (s == 0) ? 2 : ((s == 1) ? 1 : 0);
      3: return (s == 0) ? 0 : 1;
      4: return 1 + ((mode == 3) ? 0 : mode);
      default: return 0;
    endcase
  endfunction

  function automatic int expState(int op, int mode, int s);
    case (op)
      0, 3: return 0;
      1: return 1;
      2: return 2;
      4: return (mode == 3) ? 0 : mode;
      default: return s;
    endcase
  endfunction

  function automatic string reqTag(int op, int s);
    case (op)
      0: return (s == 0) ? "R3" : "R9";
      1: return (s == 2) ? "R12" : ((s == 1) ? "R11" : "R4");
      2: return (s == 2) ? "R11" : "R5";
      3: return (s == 0) ? "R11" : "R6";
      4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic runCmd(input int op, input int mode, input logic [11:0] val,
                        input bit noise, input string tagOverride);
    int s, f0, r0, g0, p0, e0, n, ef;
    string tag;
    s  = int'(pwrState);
    tag = (tagOverride != "") ? tagOverride : reqTag(op, s);
    frameWord = {4'b0000, val};
    f0 = frameCnt; r0 = resCnt; g0 = gapViol; p0 = pwrViol; e0 = edgeViol;
    @(negedge clk);
    while (busy) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'(op); cmdMode = 2'(mode);
    @(negedge clk);
    cmdValid = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      if (noise && n == 3) begin cmdValid = 1'b1; cmdOp = 3'd0; end
      if (noise && n == 4) cmdValid = 1'b0;
      @(negedge clk);
    end
    ef = expFrames(op, mode, s);
    check(frameCnt - f0 == ef, tag, "frame count", frameCnt - f0, ef);
    check(int'(pwrState) == expState(op, mode, s), tag, "pwrState", int'(pwrState), expState(op, mode, s));
    check(modelSt == expState(op, mode, s), tag, "converter model state", modelSt, expState(op, mode, s));
    check(resCnt - r0 == ((op == 0) ? 1 : 0), (op == 0) ? "R3" : "R6", "result strobes", resCnt - r0, (op == 0) ? 1 : 0);
    if (op == 0) check(lastRes == val, "R3", "result data", int'(lastRes), int'(val));
    if (ef == 0) check(n == 1, "R11", "busy cycles", n, 1);
    check(edgeViol == e0, "R4", "abort/full edge counts", edgeViol - e0, 0);
    check(gapViol == g0, "R8", "quiet gap violations", gapViol - g0, 0);
    check(pwrViol == p0, "R7", "power-up wait violations", pwrViol - p0, 0);
    if (op == 0 && s == 1)
      check(lastGap < QUIET + PWRUP, "R9", "no power-up wait from partial", lastGap, QUIET);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b1, "R1", "csN/sclk in reset", int'({csN, sclk}), 3);
    check(busy === 1'b0 && resValid === 1'b0, "R1", "busy/resValid in reset", int'({busy, resValid}), 0);
    check(pwrState === 2'd2, "R1", "pwrState in reset", int'(pwrState), 2);
    rstN = 1'b1;
    @(negedge clk);
    check(csN === 1'b1 && busy === 1'b0 && pwrState === 2'd2, "R1", "state after reset", int'({csN, busy, pwrState}), 6);

    // Sweep every op from every starting state
    for (int s = 0; s < 3; s++) begin
      for (int op = 0; op < 8; op++) begin
        runCmd(4, s, 12'h000, 1'b0, "R10");
        runCmd(op, (op == 4) ? (s + 1) % 3 : 0, 12'(12'h9C3 + op * 37 + s), 1'b0, "");
      end
    end
    runCmd(4, 3, 12'h000, 1'b0, "R10");

    // Result data patterns in normal state
    runCmd(0, 0, 12'h000, 1'b0, "R3");
    runCmd(0, 0, 12'hFFF, 1'b0, "R3");
    runCmd(0, 0, 12'hA5A, 1'b0, "R3");
    for (int b = 0; b < 12; b++) runCmd(0, 0, 12'(1 << b), 1'b0, "R3");

    // Request during a sequence must be ignored
    runCmd(2, 0, 12'h123, 1'b1, "R2");
    runCmd(3, 0, 12'h456, 1'b1, "R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule